// File: doc/BRIEF.md
# Status and Message-In Command Sequencer

This block carries out one bus command: a status phase followed at once by a message-in phase, with exactly one byte in each. The host starts it by presenting command code 1Ah. The block then runs the exchange in whichever bus role the role input selects.

As target, it drives the phase lines and REQ. It sends the status byte and then the message byte, taking both from a host-filled FIFO. As initiator, it answers the remote target's REQ with ACK. It checks that each byte arrives in the expected phase and pushes both bytes into a FIFO for the host. The outcome is reported through sticky interrupt flags that feed a single interrupt line: success, command error, phase mismatch.

The host must tell the block whether a bus connection exists. A command issued while unconnected is refused. The refusal raises the error flags and causes no bus activity.

Top module: `status_msg_seq`

## Requirements
- R1: Only command code 8'h1A, presented with `cmd_valid` while `busy` is low, starts a sequence; `busy` is high from the next cycle. Any other code, or any code while busy, has no effect on `busy`, the flags or the bus.
- R2: A 1Ah command accepted while `connected` is low sets `int_cmderr` and `int_scsi2` and raises `irq` on the next cycle. `busy` stays low and neither REQ nor ACK is driven.
- R3: In target role (`role_tgt`=1) the first byte popped from the FIFO is sent with phase 3'b011 (status), and the second byte popped is sent with phase 3'b111 (message-in). Phase bits are {MSG, C/D, I/O}.
- R4: In target role a byte is popped only when `fifo_empty` is low. While the FIFO is empty, `bus_req_o` stays low, and the sequence resumes once data is present, whether the data was written before or after the command.
- R5: In target role `bus_req_o`, once raised, stays high with stable data until `bus_ack_i` is seen high. REQ then falls, and the next byte's REQ is not raised before `bus_ack_i` is seen low.
- R6: In initiator role `bus_ack_o` is low when the command starts. On `bus_req_i` with the expected phase (3'b011 first, then 3'b111), the bus byte is pushed with one `fifo_wr` pulse, and `bus_ack_o` is held high until `bus_req_i` falls.
- R7: In initiator role, a `bus_req_i` seen with any other phase ends the sequence without writing to the FIFO. It sets `int_phase_err`, raises `irq`, and leaves `bus_ack_o` low.
- R8: After the second byte's handshake completes in either role, `int_good` and `irq` are set in the cycle `busy` falls.
- R9: Each flag stays set until `int_clr` is pulsed. `irq` is high exactly while any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| connected | input | 1 | High while a bus connection exists |
| role_tgt | input | 1 | 1 = target role, 0 = initiator role |
| busy | output | 1 | Sequence in progress |
| fifo_empty | input | 1 | Outgoing FIFO has no data (target role) |
| fifo_rdata | input | DATA_W | Head of outgoing FIFO, valid while not empty |
| fifo_rd | output | 1 | Pop outgoing FIFO |
| fifo_wr | output | 1 | Push incoming FIFO (initiator role) |
| fifo_wdata | output | DATA_W | Data for incoming FIFO |
| bus_phase_o | output | 3 | Driven phase {MSG, C/D, I/O}, 0 when idle |
| bus_req_o | output | 1 | REQ driven in target role |
| bus_ack_i | input | 1 | ACK from remote initiator |
| bus_data_o | output | DATA_W | Bus data driven in target role |
| bus_phase_i | input | 3 | Phase seen from remote target |
| bus_req_i | input | 1 | REQ from remote target |
| bus_ack_o | output | 1 | ACK driven in initiator role |
| bus_data_i | input | DATA_W | Bus data from remote target |
| int_clr | input | 1 | Clears all interrupt flags |
| int_good | output | 1 | Sequence completed |
| int_cmderr | output | 1 | Command refused |
| int_scsi2 | output | 1 | Second-group bus interrupt flag, set on refusal |
| int_phase_err | output | 1 | Unexpected phase in initiator role |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
A byte-index register stuck or skipped in the target engine shows up within one handshake. Either the second byte goes out with the status phase, or a third REQ appears instead of the completion flag. A target engine that ignores the empty FIFO raises REQ with stale data within a cycle, and the bench watches this over several idle cycles. In the initiator engine a wrong expected phase appears on the very first REQ, either as a spurious phase error or as a missing FIFO push. A lost completion or refusal flag is visible on the cycle after the terminating edge, because every flag is sampled exactly one cycle after the event that sets it.

// File: rtl/smseq_pkg.sv
package smseq_pkg;
  localparam int PH_W = 3;
  localparam int CODE_W = 8;
  localparam logic [PH_W-1:0] PH_NONE   = 3'b000;
  localparam logic [PH_W-1:0] PH_STATUS = 3'b011;
  localparam logic [PH_W-1:0] PH_MSGIN  = 3'b111;
  localparam logic [CODE_W-1:0] CMD_STAT_MSG = 8'h1A;

  typedef enum logic [1:0] {T_IDLE, T_LOAD, T_REQ, T_REL} tgt_st_e;
  typedef enum logic [1:0] {I_IDLE, I_WREQ, I_ACK} ini_st_e;

  localparam int FLAG_GOOD  = 0;
  localparam int FLAG_CMDER = 1;
  localparam int FLAG_INT2  = 2;
  localparam int FLAG_PHERR = 3;
  localparam int NFLAG      = 4;
endpackage

// File: rtl/smseq_tgt.sv
module smseq_tgt
  import smseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic              ack_i,
  output logic              fifo_rd,
  output logic              req_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy,
  output logic              done
);
  tgt_st_e           state_q, state_d;
  logic              idx_q, idx_d;
  logic              data_en;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    data_en = 1'b0;
    fifo_rd = 1'b0;
    done    = 1'b0;
    case (state_q)
      T_IDLE: if (start) begin
        state_d = T_LOAD;
        idx_d   = 1'b0;
      end
      T_LOAD: if (!fifo_empty) begin
        fifo_rd = 1'b1;
        data_en = 1'b1;
        state_d = T_REQ;
      end
      T_REQ: if (ack_i) state_d = T_REL;
      T_REL: if (!ack_i) begin
        if (idx_q) begin
          done    = 1'b1;
          state_d = T_IDLE;
        end else begin
          idx_d   = 1'b1;
          state_d = T_LOAD;
        end
      end
      default: state_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      idx_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= fifo_rdata;
  end

  assign req_o   = (state_q == T_REQ);
  assign busy    = (state_q != T_IDLE);
  assign data_o  = data_q;
  assign phase_o = !busy ? PH_NONE : (idx_q ? PH_MSGIN : PH_STATUS);
endmodule

// File: rtl/smseq_ini.sv
module smseq_ini
  import smseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              busy,
  output logic              done,
  output logic              ph_err
);
  ini_st_e         state_q, state_d;
  logic            idx_q, idx_d;
  logic [PH_W-1:0] exp_phase;

  assign exp_phase = idx_q ? PH_MSGIN : PH_STATUS;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fifo_wr = 1'b0;
    done    = 1'b0;
    ph_err  = 1'b0;
    case (state_q)
      I_IDLE: if (start) begin
        state_d = I_WREQ;
        idx_d   = 1'b0;
      end
      I_WREQ: if (req_i) begin
        if (phase_i == exp_phase) begin
          fifo_wr = 1'b1;
          state_d = I_ACK;
        end else begin
          ph_err  = 1'b1;
          state_d = I_IDLE;
        end
      end
      I_ACK: if (!req_i) begin
        if (idx_q) begin
          done    = 1'b1;
          state_d = I_IDLE;
        end else begin
          idx_d   = 1'b1;
          state_d = I_WREQ;
        end
      end
      default: state_d = I_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= I_IDLE;
      idx_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign ack_o      = (state_q == I_ACK);
  assign busy       = (state_q != I_IDLE);
  assign fifo_wdata = data_i;
endmodule

// File: rtl/smseq_flags.sv
module smseq_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          clr,
  output logic [NF-1:0] flags,
  output logic          irq
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic bit_q;
    logic bit_en;
    assign bit_en = set[g] | clr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= set[g];
    end
    assign flags[g] = bit_q;
  end

  assign irq = |flags;
endmodule

// File: rtl/status_msg_seq.sv
module status_msg_seq
  import smseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              connected,
  input  logic              role_tgt,
  output logic              busy,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic [PH_W-1:0]   bus_phase_o,
  output logic              bus_req_o,
  input  logic              bus_ack_i,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [PH_W-1:0]   bus_phase_i,
  input  logic              bus_req_i,
  output logic              bus_ack_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              int_clr,
  output logic              int_good,
  output logic              int_cmderr,
  output logic              int_scsi2,
  output logic              int_phase_err,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             accept, start_t, start_i, refuse;
  logic             busy_t, busy_i, done_t, done_i, ph_err;
  logic [NFLAG-1:0] flag_set, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign busy    = busy_t | busy_i;
  assign accept  = cmd_valid && (cmd_code == CMD_STAT_MSG) && !busy;
  assign refuse  = accept && !connected;
  assign start_t = accept && connected && role_tgt;
  assign start_i = accept && connected && !role_tgt;

  smseq_tgt #(.DATA_W(DATA_W)) u_tgt (
    .clk(clk), .rst_n(rst_s_n), .start(start_t),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .ack_i(bus_ack_i),
    .fifo_rd(fifo_rd), .req_o(bus_req_o), .phase_o(bus_phase_o),
    .data_o(bus_data_o), .busy(busy_t), .done(done_t)
  );

  smseq_ini #(.DATA_W(DATA_W)) u_ini (
    .clk(clk), .rst_n(rst_s_n), .start(start_i),
    .req_i(bus_req_i), .phase_i(bus_phase_i), .data_i(bus_data_i),
    .ack_o(bus_ack_o), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .busy(busy_i), .done(done_i), .ph_err(ph_err)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_GOOD]  = done_t | done_i;
    flag_set[FLAG_CMDER] = refuse;
    flag_set[FLAG_INT2]  = refuse;
    flag_set[FLAG_PHERR] = ph_err;
  end

  smseq_flags #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_s_n), .set(flag_set), .clr(int_clr),
    .flags(flags), .irq(irq)
  );

  assign int_good      = flags[FLAG_GOOD];
  assign int_cmderr    = flags[FLAG_CMDER];
  assign int_scsi2     = flags[FLAG_INT2];
  assign int_phase_err = flags[FLAG_PHERR];
endmodule

// File: rtl/smseq_chk.sv
module smseq_chk
  import smseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CODE_W-1:0] cmd_code,
  input logic              connected,
  input logic              busy,
  input logic              fifo_empty,
  input logic              fifo_rd,
  input logic              fifo_wr,
  input logic [PH_W-1:0]   bus_phase_o,
  input logic              bus_req_o,
  input logic              bus_ack_i,
  input logic [DATA_W-1:0] bus_data_o,
  input logic [PH_W-1:0]   bus_phase_i,
  input logic              bus_req_i,
  input logic              bus_ack_o,
  input logic              int_clr,
  input logic              int_good,
  input logic              int_cmderr,
  input logic              int_scsi2,
  input logic              int_phase_err,
  input logic              irq
);
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code != CMD_STAT_MSG) && !busy |=> !busy); // R1
  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == CMD_STAT_MSG) && !busy && !connected
    |=> int_cmderr && int_scsi2 && irq && !busy); // R2
  AST_REQ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_phase_o == PH_STATUS || bus_phase_o == PH_MSGIN)); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o); // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && $past(bus_req_o) |-> $stable(bus_data_o)); // R5
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_o) |-> $past(bus_req_i)); // R6
  AST_PUSH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (bus_phase_i == PH_STATUS || bus_phase_i == PH_MSGIN)); // R6
  AST_PHERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_phase_err) |-> !busy && !bus_ack_o); // R7
  AST_GOOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_good) |-> !busy && irq); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    int_good && !int_clr |=> int_good); // R9
endmodule

bind status_msg_seq smseq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_s_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .connected(connected), .busy(busy), .fifo_empty(fifo_empty),
  .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .bus_phase_o(bus_phase_o),
  .bus_req_o(bus_req_o), .bus_ack_i(bus_ack_i), .bus_data_o(bus_data_o),
  .bus_phase_i(bus_phase_i), .bus_req_i(bus_req_i), .bus_ack_o(bus_ack_o),
  .int_clr(int_clr), .int_good(int_good), .int_cmderr(int_cmderr),
  .int_scsi2(int_scsi2), .int_phase_err(int_phase_err), .irq(irq)
);

// File: tb/test_status_msg_seq.sv
module test_status_msg_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       connected = 1'b1;
  logic       role_tgt = 1'b1;
  logic       busy;
  logic       fifo_empty;
  logic [7:0] fifo_rdata;
  logic       fifo_rd, fifo_wr;
  logic [7:0] fifo_wdata;
  logic [2:0] bus_phase_o;
  logic       bus_req_o;
  logic       bus_ack_i = 1'b0;
  logic [7:0] bus_data_o;
  logic [2:0] bus_phase_i = 3'b000;
  logic       bus_req_i = 1'b0;
  logic       bus_ack_o;
  logic [7:0] bus_data_i = 8'h00;
  logic       int_clr = 1'b0;
  logic       int_good, int_cmderr, int_scsi2, int_phase_err, irq;

  int checks = 0;
  int failures = 0;

  status_msg_seq i_status_msg_seq (.*);

  // outgoing FIFO model
  logic [7:0] fmem [4];
  logic [2:0] wp = 3'd0;
  logic [2:0] rp = 3'd0;
  assign fifo_empty = (wp == rp);
  assign fifo_rdata = fmem[rp[1:0]];
  always @(posedge clk) if (fifo_rd) rp <= rp + 3'd1;

  // incoming FIFO capture
  logic [7:0] cap [4];
  int ncap = 0;
  always @(posedge clk) if (fifo_wr) begin
    cap[ncap % 4] <= fifo_wdata;
    ncap <= ncap + 1;
  end

  function automatic logic [2:0] exp_phase(int b);
    return (b == 0) ? 3'b011 : 3'b111;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    fmem[wp[1:0]] = b;
    wp = wp + 3'd1;
  endtask

  task automatic issue(logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) int_clr = 1'b1;
    @(negedge clk) int_clr = 1'b0;
    check(irq == 1'b0 && int_good == 1'b0, "R9", "irq after clear", irq, 0);
  endtask

  task automatic run_tgt(logic [7:0] st, logic [7:0] msg, bit prefill,
                         int hold, int ackdly);
    role_tgt = 1'b1;
    if (prefill) begin push(st); push(msg); end
    issue(8'h1A);
    check(busy == 1'b1, "R1", "busy after 1Ah", busy, 1);
    for (int b = 0; b < 2; b++) begin
      if (!prefill) begin
        for (int k = 0; k < hold; k++) begin
          @(negedge clk);
          check(bus_req_o == 1'b0, "R4", "REQ while FIFO empty", bus_req_o, 0);
        end
        push(b == 0 ? st : msg);
      end
      for (int t = 0; t < 100 && !bus_req_o; t++) @(negedge clk);
      check(bus_req_o == 1'b1, "R5", "REQ raised", bus_req_o, 1);
      check(bus_data_o == (b == 0 ? st : msg), "R3", "byte sent",
            bus_data_o, (b == 0 ? st : msg));
      check(bus_phase_o == exp_phase(b), "R3", "phase sent", bus_phase_o, exp_phase(b));
      for (int k = 0; k < ackdly; k++) @(negedge clk);
      check(bus_req_o == 1'b1, "R5", "REQ held until ACK", bus_req_o, 1);
      bus_ack_i = 1'b1;
      for (int t = 0; t < 100 && bus_req_o; t++) @(negedge clk);
      check(bus_req_o == 1'b0, "R5", "REQ released on ACK", bus_req_o, 0);
      repeat (2) @(negedge clk);
      check(bus_req_o == 1'b0, "R5", "no REQ while ACK high", bus_req_o, 0);
      bus_ack_i = 1'b0;
    end
    @(negedge clk);
    check(int_good == 1'b1 && irq == 1'b1 && busy == 1'b0, "R8",
          "good after target run", {int_good, irq, busy}, 3'b110);
    repeat (3) @(negedge clk);
    check(int_good == 1'b1, "R9", "good sticky", int_good, 1);
    clear_flags();
  endtask

  task automatic run_ini(logic [7:0] st, logic [7:0] msg, bit bad);
    int n0;
    n0 = ncap;
    role_tgt = 1'b0;
    issue(8'h1A);
    check(bus_ack_o == 1'b0 && busy == 1'b1, "R6", "ACK low at start",
          {bus_ack_o, busy}, 2'b01);
    for (int b = 0; b < 2; b++) begin
      repeat (2) @(negedge clk);
      bus_phase_i = (bad && b == 1) ? 3'b010 : exp_phase(b);
      bus_data_i  = (b == 0) ? st : msg;
      bus_req_i   = 1'b1;
      if (bad && b == 1) begin
        @(negedge clk);
        bus_req_i = 1'b0;
        check(int_phase_err == 1'b1 && irq == 1'b1, "R7", "phase error flag",
              int_phase_err, 1);
        check(busy == 1'b0 && bus_ack_o == 1'b0, "R7", "abort idle",
              {busy, bus_ack_o}, 0);
        check(ncap - n0 == 1, "R7", "no push on mismatch", ncap - n0, 1);
        check(int_good == 1'b0, "R7", "no good on mismatch", int_good, 0);
        clear_flags();
        return;
      end
      for (int t = 0; t < 100 && !bus_ack_o; t++) @(negedge clk);
      check(bus_ack_o == 1'b1, "R6", "ACK answers REQ", bus_ack_o, 1);
      check(ncap - n0 == b + 1, "R6", "push count", ncap - n0, b + 1);
      check(cap[(n0 + b) % 4] == bus_data_i, "R6", "pushed byte",
            cap[(n0 + b) % 4], bus_data_i);
      repeat (2) @(negedge clk);
      check(bus_ack_o == 1'b1, "R6", "ACK held while REQ", bus_ack_o, 1);
      bus_req_i = 1'b0;
      for (int t = 0; t < 100 && bus_ack_o; t++) @(negedge clk);
      check(bus_ack_o == 1'b0, "R6", "ACK released", bus_ack_o, 0);
    end
    check(int_good == 1'b1 && busy == 1'b0, "R8", "good after initiator run",
          {int_good, busy}, 2'b10);
    clear_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && irq == 1'b0 && bus_req_o == 1'b0 && bus_ack_o == 1'b0,
          "R9", "reset state", {busy, irq, bus_req_o, bus_ack_o}, 0);

    // R1: wrong code ignored
    issue(8'h1B);
    check(busy == 1'b0 && irq == 1'b0, "R1", "other code ignored", {busy, irq}, 0);
    repeat (2) @(negedge clk);
    check(bus_req_o == 1'b0 && bus_ack_o == 1'b0 && !fifo_rd, "R1", "no bus on other code",
          {bus_req_o, bus_ack_o}, 0);

    // R2: refused while disconnected
    connected = 1'b0;
    issue(8'h1A);
    check(int_cmderr && int_scsi2 && irq, "R2", "refusal flags",
          {int_cmderr, int_scsi2, irq}, 3'b111);
    check(busy == 1'b0, "R2", "not busy after refusal", busy, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(bus_req_o == 1'b0 && bus_ack_o == 1'b0, "R2", "no bus on refusal",
            {bus_req_o, bus_ack_o}, 0);
    end
    clear_flags();
    connected = 1'b1;

    // directed corners
    run_tgt(8'h00, 8'hFF, 1'b1, 0, 0);
    run_tgt(8'h02, 8'h04, 1'b0, 3, 2);
    run_ini(8'h08, 8'h80, 1'b0);
    run_ini(8'h18, 8'h07, 1'b1);

    // R1: second command while busy ignored (target waits on empty FIFO)
    role_tgt = 1'b1;
    issue(8'h1A);
    issue(8'h1A);
    @(negedge clk);
    check(busy == 1'b1 && irq == 1'b0, "R1", "command while busy ignored",
          {busy, irq}, 2'b10);
    push(8'h55); push(8'hAA);
    for (int b = 0; b < 2; b++) begin
      for (int t = 0; t < 100 && !bus_req_o; t++) @(negedge clk);
      check(bus_data_o == (b == 0 ? 8'h55 : 8'hAA), "R3", "byte after busy cmd",
            bus_data_o, (b == 0 ? 8'h55 : 8'hAA));
      bus_ack_i = 1'b1;
      for (int t = 0; t < 100 && bus_req_o; t++) @(negedge clk);
      bus_ack_i = 1'b0;
    end
    @(negedge clk);
    check(int_good == 1'b1 && busy == 1'b0, "R8", "single completion", {int_good, busy}, 2'b10);
    clear_flags();

    // random mix
    for (int it = 0; it < 20; it++) begin
      logic [7:0] st, msg;
      st  = 8'($urandom);
      msg = 8'($urandom);
      if ($urandom % 2 == 0)
        run_tgt(st, msg, 1'($urandom % 2), 1 + int'($urandom % 4), int'($urandom % 3));
      else
        run_ini(st, msg, ($urandom % 4) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule